// File: doc/BRIEF.md
# Clock-Stop SPI Master Engine

This block is a serial-port engine that acts as an SPI master and keeps its serial clock stopped between words. A word transfer begins with a one-cycle start strobe that carries a parallel transmit word, a word length and a clock divider value. The engine pulls its active-low select line down. After half a serial-clock period it produces the first rising clock edge. It then shifts the word out most significant bit first and captures the returning data on the falling edges. Half a period after the last falling edge it raises select, stops driving the data line and presents the received word with a one-cycle done pulse.

The serial clock is derived from the system clock. With divider value D the serial period is 2·(D+1) system cycles. The duty cycle depends on the parity of D. An odd D, or D equal to zero, gives a low phase of D+1 cycles. An even, non-zero D gives a low phase of D cycles, and the high phase takes the rest of the period. The serial clock idles low, so a slave sees no clock edges outside a word.

Top module: `spi_cs_master`

## Requirements
- R1: After reset and between words, sclk_o is 0, sel_n_o is 1, sdo_oe_o is 0, sdo_o is 0 and done_o is 0.
- R2: During a word, consecutive rising edges of sclk_o are exactly 2·(D+1) system cycles apart, where D is the divider value taken at start.
- R3: Each high phase of sclk_o lasts 2·(D+1)−L cycles. L is D+1 when D is zero or odd, and D when D is even and non-zero.
- R4: sel_n_o falls in the cycle after the start strobe is accepted, and the first rising edge of sclk_o follows exactly L cycles later.
- R5: Transmit data leaves most significant bit first. The first bit is on sdo_o from the moment select falls, and each later bit appears with the rising edge that starts its clock period. sdo_o does not change while sclk_o is high.
- R6: sdi_i is sampled on each falling edge of sclk_o. The received word is right-aligned in rx_data_o, with the first received bit as the most significant of the word and zeros above the word length.
- R7: Exactly L cycles after the last falling edge, sel_n_o returns to 1 and sdo_oe_o to 0, and done_o pulses for one cycle with the received word on rx_data_o.
- R8: A transfer carries exactly N bits, where N is len_i clamped to the range 8..32: values below 8 give 8 bits and values above 32 give 32 bits.
- R9: A start strobe that arrives during a word is ignored: the word in progress is unchanged and no further word follows it.
- R10: div_i, len_i and tx_data_i are taken only when a start strobe is accepted. Changing them during a word does not alter its timing or data.
- R11: sclk_o is high only while sel_n_o is low, and sdo_oe_o is high exactly while sel_n_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Serial-clock divider value D |
| len_i | input | LEN_W | Word length in bits (clamped to 8..32) |
| tx_data_i | input | MAX_W | Transmit word, right-aligned |
| start_i | input | 1 | Start strobe, accepted only when idle |
| rx_data_o | output | MAX_W | Received word, right-aligned, valid with done_o |
| done_o | output | 1 | One-cycle pulse at the end of a word |
| sclk_o | output | 1 | Serial clock, idles low |
| sel_n_o | output | 1 | Active-low select |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| sdi_i | input | 1 | Serial data in |

## Verification
Several rules are checked by assertions on every cycle. The clock only runs while select is low, the output enable follows select, the data line stays stable through every high phase, done lasts one cycle and comes with the rise of select, the latched divider holds steady during a word, and the phase counter steps down by one. Only the bench's scenarios can show the cycle counts themselves. These are the lead and tail lengths, the parity-dependent split of high and low phases, the bit order on both data lines, the clamping of the word length, and the effect of a start strobe or a changed divider during a word. The bench measures these at the pins with a slave model.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } spi_state_e;

endpackage

// File: rtl/spi_cs_phase_calc.sv
module spi_cs_phase_calc #(
    parameter int DIV_W = 8,
    parameter int CNT_W = DIV_W + 2
) (
    input  logic [DIV_W-1:0] div_i,
    output logic [CNT_W-1:0] low_len_o,
    output logic [CNT_W-1:0] high_len_o
);

    logic [CNT_W-1:0] div_ext;
    logic [CNT_W-1:0] period;

    always_comb begin
        div_ext = CNT_W'(div_i);
        period  = (div_ext + CNT_W'(1)) << 1;
        if ((div_i == '0) || div_i[0]) begin
            low_len_o = div_ext + CNT_W'(1);
        end else begin
            low_len_o = div_ext;
        end
        high_len_o = period - low_len_o;
    end

    // R3
    always_comb begin
        low_phase_nonzero_chk: assert (low_len_o != '0 || $isunknown(div_i));
    end

endmodule

// File: rtl/spi_cs_timer.sv
module spi_cs_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = (cnt_q == '0);

    // R2
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/spi_cs_shifter.sv
module spi_cs_shifter #(
    parameter int MAX_W = 32,
    parameter int LEN_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [MAX_W-1:0] tx_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             shift_i,
    input  logic             sample_i,
    input  logic             sdi_i,
    output logic             msb_o,
    output logic [MAX_W-1:0] rx_o
);

    typedef struct packed {
        logic [MAX_W-1:0] tx;
        logic [MAX_W-1:0] rx;
    } shreg_t;

    shreg_t           sh_d, sh_q;
    logic [LEN_W-1:0] align;

    always_comb begin
        sh_d  = sh_q;
        align = LEN_W'(MAX_W) - len_i;
        if (load_i) begin
            sh_d.tx = tx_i << align;
            sh_d.rx = '0;
        end else begin
            if (shift_i) begin
                sh_d.tx = {sh_q.tx[MAX_W-2:0], 1'b0};
            end
            if (sample_i) begin
                sh_d.rx = {sh_q.rx[MAX_W-2:0], sdi_i};
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign msb_o = sh_q.tx[MAX_W-1];
    assign rx_o  = sh_q.rx;

    // R5
    edge_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(shift_i && sample_i));

endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master #(
    parameter int DIV_W = 8,
    parameter int MAX_W = 32,
    parameter int MIN_W = 8,
    parameter int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [MAX_W-1:0] tx_data_i,
    input  logic             start_i,
    output logic [MAX_W-1:0] rx_data_o,
    output logic             done_o,
    output logic             sclk_o,
    output logic             sel_n_o,
    output logic             sdo_o,
    output logic             sdo_oe_o,
    input  logic             sdi_i
);

    import spi_cs_pkg::*;

    localparam int CNT_W = DIV_W + 2;

    typedef struct packed {
        spi_state_e       st;
        logic [LEN_W-1:0] nbits;
        logic [LEN_W-1:0] bits;
        logic [DIV_W-1:0] div;
        logic             sclk;
        logic             sel_n;
        logic             oe;
        logic             done;
        logic [MAX_W-1:0] rx;
    } ctl_t;

    ctl_t             c_d, c_q;
    logic [LEN_W-1:0] eff_len;
    logic [DIV_W-1:0] div_use;
    logic [CNT_W-1:0] low_len, high_len;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expire;
    logic             tx_load, tx_shift, rx_sample;
    logic             tx_msb;
    logic [MAX_W-1:0] rx_shreg;

    always_comb begin
        if (len_i < LEN_W'(MIN_W)) begin
            eff_len = LEN_W'(MIN_W);
        end else if (len_i > LEN_W'(MAX_W)) begin
            eff_len = LEN_W'(MAX_W);
        end else begin
            eff_len = len_i;
        end
    end

    assign div_use = (c_q.st == ST_IDLE) ? div_i : c_q.div;

    spi_cs_phase_calc #(
        .DIV_W(DIV_W),
        .CNT_W(CNT_W)
    ) phase_i (
        .div_i     (div_use),
        .low_len_o (low_len),
        .high_len_o(high_len)
    );

    spi_cs_timer #(
        .CNT_W(CNT_W)
    ) timer_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .expire_o  (tmr_expire)
    );

    spi_cs_shifter #(
        .MAX_W(MAX_W),
        .LEN_W(LEN_W)
    ) shifter_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (tx_load),
        .tx_i    (tx_data_i),
        .len_i   (eff_len),
        .shift_i (tx_shift),
        .sample_i(rx_sample),
        .sdi_i   (sdi_i),
        .msb_o   (tx_msb),
        .rx_o    (rx_shreg)
    );

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = low_len - CNT_W'(1);
        tx_load   = 1'b0;
        tx_shift  = 1'b0;
        rx_sample = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.st    = ST_LEAD;
                    c_d.div   = div_i;
                    c_d.nbits = eff_len;
                    c_d.bits  = '0;
                    c_d.sel_n = 1'b0;
                    c_d.oe    = 1'b1;
                    c_d.sclk  = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = low_len - CNT_W'(1);
                    tx_load   = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tmr_expire) begin
                    c_d.st   = ST_HIGH;
                    c_d.sclk = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = high_len - CNT_W'(1);
                end
            end
            ST_HIGH: begin
                if (tmr_expire) begin
                    c_d.sclk  = 1'b0;
                    rx_sample = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = low_len - CNT_W'(1);
                    if (c_q.bits == c_q.nbits - LEN_W'(1)) begin
                        c_d.st = ST_TAIL;
                    end else begin
                        c_d.st   = ST_LOW;
                        c_d.bits = c_q.bits + LEN_W'(1);
                    end
                end
            end
            ST_LOW: begin
                if (tmr_expire) begin
                    c_d.st   = ST_HIGH;
                    c_d.sclk = 1'b1;
                    tx_shift = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = high_len - CNT_W'(1);
                end
            end
            ST_TAIL: begin
                if (tmr_expire) begin
                    c_d.st    = ST_IDLE;
                    c_d.sel_n = 1'b1;
                    c_d.oe    = 1'b0;
                    c_d.done  = 1'b1;
                    c_d.rx    = rx_shreg;
                end
            end
            default: begin
                c_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q       <= '0;
            c_q.st    <= ST_IDLE;
            c_q.sel_n <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign rx_data_o = c_q.rx;
    assign done_o    = c_q.done;
    assign sclk_o    = c_q.sclk;
    assign sel_n_o   = c_q.sel_n;
    assign sdo_oe_o  = c_q.oe;
    assign sdo_o     = c_q.oe & tx_msb;

    // R11
    clk_only_selected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sclk_o |-> !sel_n_o);

    // R11
    oe_follows_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sdo_oe_o == !sel_n_o);

    // R5
    sdo_steady_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

    // R7
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R7
    done_with_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sel_n_o) |-> done_o);

    // R10
    div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_q.st != ST_IDLE && $past(c_q.st != ST_IDLE)) |-> $stable(c_q.div));

endmodule

// File: tb/spi_cs_master_tb_top.sv
module spi_cs_master_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;
    localparam int MAX_W      = 32;
    localparam int LEN_W      = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_i = '0;
    logic [LEN_W-1:0] len_i = '0;
    logic [MAX_W-1:0] tx_data_i = '0;
    logic             start_i = 1'b0;
    logic [MAX_W-1:0] rx_data_o;
    logic             done_o, sclk_o, sel_n_o, sdo_o, sdo_oe_o;
    logic             sdi_i = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cs_master #(
        .DIV_W(DIV_W), .MAX_W(MAX_W), .MIN_W(8), .LEN_W(LEN_W)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .div_i(div_i), .len_i(len_i),
        .tx_data_i(tx_data_i), .start_i(start_i), .rx_data_o(rx_data_o),
        .done_o(done_o), .sclk_o(sclk_o), .sel_n_o(sel_n_o), .sdo_o(sdo_o),
        .sdo_oe_o(sdo_oe_o), .sdi_i(sdi_i)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int eff_len(input int len);
        if (len < 8) return 8;
        if (len > 32) return 32;
        return len;
    endfunction

    function automatic int low_len(input int d);
        if (d == 0 || (d % 2) == 1) return d + 1;
        return d;
    endfunction

    function automatic logic [31:0] word_mask(input int n);
        if (n >= 32) return 32'hFFFF_FFFF;
        return (32'd1 << n) - 32'd1;
    endfunction

    task automatic check_idle(input int ncyc, input string tag);
        int bad = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (sclk_o !== 1'b0 || sel_n_o !== 1'b1 || sdo_oe_o !== 1'b0 ||
                sdo_o !== 1'b0 || done_o !== 1'b0) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic run_word(input int d, input int len, input logic [31:0] tx,
                            input logic [31:0] slv, input bit disturb);
        int n = eff_len(len);
        int lo = low_len(d);
        int per = 2 * (d + 1);
        int hi = per - lo;
        int rise_t[64];
        int fall_t[64];
        int nr = 0, nf = 0, t = 0, tsel = -1, tdone = -1;
        int bad_sel = 0, bad_sdo = 0, bad_per = 0, bad_hi = 0, bad_rel = 0;
        logic prev = 1'b0, last_sdo = 1'b0, first_sdo = 1'b0, first_oe = 1'b0;
        logic [31:0] got = '0, rxv = '0;
        logic [31:0] m = word_mask(n);

        @(negedge clk);
        div_i = DIV_W'(d);
        len_i = LEN_W'(len);
        tx_data_i = tx;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (tdone < 0 && t < 20000) begin
            if (t == 0) begin
                first_sdo = sdo_o;
                first_oe = sdo_oe_o;
            end
            if (sel_n_o == 1'b0 && tsel < 0) tsel = t;
            if (sclk_o && sel_n_o) bad_sel++;
            if (!sel_n_o && !sdo_oe_o) bad_sel++;
            if (sclk_o && !prev) begin
                if (nr < 64) rise_t[nr] = t;
                if (nr < n) sdi_i = slv[n-1-nr];
                nr++;
                last_sdo = sdo_o;
            end else if (sclk_o && prev && sdo_o != last_sdo) begin
                bad_sdo++;
            end
            if (!sclk_o && prev) begin
                if (nf < 64) fall_t[nf] = t;
                got = {got[30:0], sdo_o};
                nf++;
            end
            if (done_o) begin
                tdone = t;
                rxv = rx_data_o;
                if (sel_n_o !== 1'b1 || sdo_oe_o !== 1'b0) bad_rel++;
            end
            if (disturb && t == 3) begin
                start_i = 1'b1;
                div_i = DIV_W'(d + 3);
                len_i = LEN_W'(8);
                tx_data_i = ~tx;
            end else begin
                start_i = 1'b0;
            end
            prev = sclk_o;
            t++;
            @(negedge clk);
        end
        chk(done_o == 1'b0, "R7 done pulse width", done_o, 0);
        chk(tdone >= 0, "R7 done seen", tdone, 1);
        chk(nr == n && nf == n, "R8 bit count", nr, n);
        chk(tsel == 0 && nr > 0 && rise_t[0] - tsel == lo, "R4 lead length",
            (nr > 0) ? rise_t[0] - tsel : -1, lo);
        chk(first_oe == 1'b1 && first_sdo == tx[n-1], "R5 first bit at select",
            first_sdo, tx[n-1]);
        for (int i = 1; i < nr && i < 64; i++)
            if (rise_t[i] - rise_t[i-1] != per) bad_per++;
        chk(bad_per == 0, "R2 serial period", bad_per, 0);
        for (int i = 0; i < nf && i < nr && i < 64; i++)
            if (fall_t[i] - rise_t[i] != hi) bad_hi++;
        chk(bad_hi == 0, "R3 high phase", bad_hi, 0);
        chk(bad_sdo == 0, "R5 sdo steady while high", bad_sdo, 0);
        chk((got & m) == (tx & m), "R5 msb-first data", got & m, tx & m);
        chk(rxv == (slv & m), "R6 received word", rxv, slv & m);
        chk(nf > 0 && nf <= 64 && bad_rel == 0 && tdone - fall_t[nf-1] == lo,
            "R7 tail length", (nf > 0 && nf <= 64) ? tdone - fall_t[nf-1] : -1, lo);
        chk(bad_sel == 0, "R11 clock only under select", bad_sel, 0);
        if (disturb) begin
            chk(bad_per == 0 && bad_hi == 0 && nr == n, "R10 inputs ignored mid-word",
                bad_per + bad_hi, 0);
            check_idle(2 * per + 4, "R9 no second word after mid-word start");
        end else begin
            check_idle(3, "R1 idle between words");
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(sclk_o === 1'b0 && sel_n_o === 1'b1 && sdo_oe_o === 1'b0 &&
            sdo_o === 1'b0 && done_o === 1'b0, "R1 reset state", sel_n_o, 1);
        rst_n = 1'b1;
        check_idle(4, "R1 idle after reset");

        run_word(0, 8, 32'h0000_00A5, 32'h0000_003C, 0);
        run_word(1, 8, 32'h0000_0081, 32'h0000_00FF, 0);
        run_word(2, 16, 32'h0000_BEEF, 32'h0000_1234, 0);
        run_word(4, 12, 32'h0000_0F0F, 32'h0000_0ABC, 0);
        run_word(3, 32, 32'hDEAD_BEEF, 32'hCAFE_F00D, 0);
        run_word(0, 3, 32'h0000_005A, 32'h0000_00C3, 0);
        run_word(2, 50, 32'h8000_0001, 32'h7FFF_FFFE, 0);
        run_word(1, 10, 32'h0000_02AA, 32'h0000_0155, 1);
        run_word(6, 9, 32'h0000_01FF, 32'h0000_0100, 1);

        for (int k = 0; k < 40; k++) begin
            int d = int'($urandom_range(0, 6));
            int l = int'($urandom_range(0, 40));
            run_word(d, l, $urandom, $urandom, k % 7 == 3);
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule